// File: doc/BRIEF.md
# Programmable Clock Output Generator

The block builds an output clock from one of several auxiliary input clocks. A select field picks the source clock, and an integer divisor sets the output period in cycles of that clock. All the generator logic runs in the domain of the selected clock. The enable input is brought into that domain through a synchroniser, so the output starts and stops only at period boundaries and never emits a shortened pulse. A separate kill input clears the generator at once, with no need for a clock edge.

A two-bit start delay holds back the internal enable by zero to three input cycles. Software sets it before enabling the output, to line up the phases of several generators. Each edge on the nudge input, rising or falling, slips the output phase by one input cycle. It does this by holding the period counter for one cycle. For odd divisors, an optional duty-cycle correction adds a copy of the output retimed on the falling edge. The high and low times then both come out at N/2 input cycles. The source select is not glitch-free, so software changes it only while the generator is disabled. Every other control may change while the clock runs.

Top module: `clkout_gen`

## Requirements
- R1: While `rst_n` is low, and whenever the generator has stopped with `en` low, `clk_out` stays low, even if `en` is high during reset.
- R2: For a divisor value d from 2 to 255, N = d; d = 0 means N = 256. The output period is N selected-clock cycles. With correction off, or for even N, the output is high for floor(N/2) cycles starting at a rising input edge and low for the rest of the period.
- R3: With d = 1, `clk_out` is the selected input clock, gated so that only whole input pulses pass while the generator runs.
- R4: With `dc50` high and N odd (N >= 3), the high time and the low time are each N half-cycles of the selected clock.
- R5: After `en` is first seen high at a rising edge of the selected clock, the first output rising edge (N >= 2) comes on the (3 + `phase`)th later rising edge. For d = 1, the first output pulse comes one input cycle after that.
- R6: When `en` goes low, the period in progress completes with a full high time. After that, no further rising edge appears on `clk_out`.
- R7: Each change of level on `nudge`, rising or falling, lengthens exactly one output period by one selected-clock cycle. All other periods keep their length.
- R8: Raising `kill` drives `clk_out` low at once, with no clock edge needed. It stays low while `kill` is high. When `kill` falls with `en` high, the first rising edge comes on the (5 + `phase`)th selected-clock rising edge, and the first high time is full length.
- R9: `src_sel` = s picks `aux_clk[s]`. All periods and latencies are counted in that clock.
- R10: A divisor changed while the generator runs takes effect within two output periods, with no need to disable the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aux_clk | input | NSRC | Auxiliary input clocks |
| src_sel | input | $clog2(NSRC) | Index of the source clock; change only while disabled |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clean run/stop request |
| kill | input | 1 | Asynchronous stop, active high |
| div | input | DIV_W | Integer divisor, 0 means 2^DIV_W |
| phase | input | PH_W | Start delay in input cycles |
| nudge | input | 1 | Each level change slips the phase by one input cycle |
| dc50 | input | 1 | Duty-cycle correction for odd divisors |
| clk_out | output | 1 | Generated clock |

## Verification
A period counter that wraps at the wrong value shows up as a period or a high time that is off by one input cycle. The half-cycle sampling sees it on the first measured period. A fault in the enable delay path, in the reset release or in the synchroniser depth moves the first rising edge by whole input cycles, which the edge count from enable or from kill release catches. A lost or doubled nudge hold changes the sum of the following rise-to-rise intervals. A missing falling-edge copy cuts half a cycle from each odd-divisor high time.

// File: rtl/clkout_pkg.sv
`timescale 1ns/100ps
package clkout_pkg;
  // depth of every clock-domain crossing synchroniser in the generator
  localparam int unsigned CLKOUT_SYNC_DEPTH = 2;
endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/100ps
module clkout_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/clkout_div.sv
`timescale 1ns/100ps
module clkout_div #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_s,
  input  logic             nud_s,
  input  logic [DIV_W-1:0] div,
  input  logic [PH_W-1:0]  phase,
  input  logic             dc50,
  output logic             clk_out
);
  localparam int unsigned TAPS = (1 << PH_W) - 1;

  logic [DIV_W-1:0] last_cnt;
  logic [DIV_W-1:0] hi_cnt;
  logic             bypass;
  logic             odd;
  logic [TAPS-1:0]  dly_q;
  logic [TAPS:0]    taps;
  logic             en_ph;
  logic             running, run_n;
  logic [DIV_W-1:0] cnt, cnt_n;
  logic             q_pos, qp_n;
  logic             q_neg;
  logic             gate_q;
  logic             nud_q;
  logic             nud_evt;
  logic             wrap;

  // divisor decode: 0 stands for 2^DIV_W
  assign last_cnt = div - 1'b1;
  assign hi_cnt   = {(div == '0), div[DIV_W-1:1]};
  assign bypass   = (div == DIV_W'(1));
  assign odd      = div[0];

  // start delay line behind the synchronised enable
  generate
    if (TAPS == 1) begin : g_dly_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= en_s;
      end
    end else begin : g_dly_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= {dly_q[TAPS-2:0], en_s};
      end
    end
  endgenerate

  assign taps    = {dly_q, en_s};
  assign en_ph   = taps[phase];
  assign nud_evt = nud_s ^ nud_q;
  assign wrap    = (cnt >= last_cnt);

  always_comb begin
    run_n = running;
    cnt_n = cnt;
    if (!running) begin
      if (en_ph) begin
        run_n = 1'b1;
        cnt_n = '0;
      end
    end else if (nud_evt) begin
      cnt_n = cnt;
    end else if (wrap) begin
      cnt_n = '0;
      run_n = en_ph;
    end else begin
      cnt_n = cnt + 1'b1;
    end
    qp_n = run_n & (cnt_n < hi_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      q_pos   <= 1'b0;
      nud_q   <= 1'b0;
    end else begin
      running <= run_n;
      cnt     <= cnt_n;
      q_pos   <= qp_n;
      nud_q   <= nud_s;
    end
  end

  // falling-edge copies: half-cycle stretch and pass-through gate
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_neg  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      q_neg  <= q_pos;
      gate_q <= running;
    end
  end

  assign clk_out = bypass ? (clk & gate_q) : (q_pos | (dc50 & odd & q_neg));

  // R1: an idle generator never holds its output high
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !q_pos);

  // R5: a start always begins from a cleared counter after a delayed enable
  p_start_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (cnt == '0) && $past(en_ph));

  // R6: stopping happens only at a period boundary with enable gone
  p_stop_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(wrap) && !$past(en_ph));

  // R7: a nudge edge holds the counter for one cycle
  p_nudge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && nud_evt) |=> $stable(cnt) && running);
endmodule

// File: rtl/clkout_gen.sv
`timescale 1ns/100ps
module clkout_gen #(
  parameter int unsigned NSRC        = 4,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PH_W        = 2,
  parameter int unsigned SYNC_STAGES = clkout_pkg::CLKOUT_SYNC_DEPTH
) (
  input  logic [NSRC-1:0]         aux_clk,
  input  logic [$clog2(NSRC)-1:0] src_sel,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    kill,
  input  logic [DIV_W-1:0]        div,
  input  logic [PH_W-1:0]         phase,
  input  logic                    nudge,
  input  logic                    dc50,
  output logic                    clk_out
);
  logic sel_clk;
  logic arst_n;
  logic rst_i_n;
  logic en_s;
  logic nud_s;

  // plain source mux, not glitch-free
  assign sel_clk = aux_clk[src_sel];
  // kill clears the domain at once, reset and kill release through the synchroniser
  assign arst_n  = rst_n & ~kill;

  clkout_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(sel_clk), .rst_n(arst_n), .d(1'b1), .q(rst_i_n));

  clkout_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(sel_clk), .rst_n(rst_i_n), .d(en), .q(en_s));

  clkout_sync #(.STAGES(SYNC_STAGES)) u_nud_sync (
    .clk(sel_clk), .rst_n(rst_i_n), .d(nudge), .q(nud_s));

  clkout_div #(.DIV_W(DIV_W), .PH_W(PH_W)) u_div (
    .clk(sel_clk), .rst_n(rst_i_n), .en_s(en_s), .nud_s(nud_s),
    .div(div), .phase(phase), .dc50(dc50), .clk_out(clk_out));

  // R8: while kill is held the output is quiet at every input edge
  p_kill_quiet_r8: assert property (@(posedge sel_clk) disable iff (!rst_n)
    kill |-> !clk_out);
endmodule

// File: tb/clkout_gen_tb_top.sv
`timescale 1ns/100ps
module clkout_gen_tb_top;
  logic [3:0] aux_clk;
  logic [1:0] src_sel;
  logic       rst_n, en, kill, nudge, dc50;
  logic [7:0] div;
  logic [1:0] phase;
  logic       clk_out;
  logic       bclk;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  clkout_gen dut_i (
    .aux_clk(aux_clk), .src_sel(src_sel), .rst_n(rst_n), .en(en), .kill(kill),
    .div(div), .phase(phase), .nudge(nudge), .dc50(dc50), .clk_out(clk_out));

  // source 0 is the 200 MHz reference, the others are slower
  initial begin aux_clk[0] = 0; forever #2.5 aux_clk[0] = ~aux_clk[0]; end
  initial begin aux_clk[1] = 0; forever #4.0 aux_clk[1] = ~aux_clk[1]; end
  initial begin aux_clk[2] = 0; forever #3.0 aux_clk[2] = ~aux_clk[2]; end
  initial begin aux_clk[3] = 0; forever #5.0 aux_clk[3] = ~aux_clk[3]; end
  assign bclk = aux_clk[src_sel];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic half_s(output logic s);
    @(posedge bclk or negedge bclk);
    #1;
    s = clk_out;
  endtask

  task automatic measure(output int hi, output int lo);
    logic s;
    int g;
    hi = -1; lo = -1;
    g = 0; do begin half_s(s); g++; end while (s && g < 3000);
    g = 0; do begin half_s(s); g++; end while (!s && g < 3000);
    if (g >= 3000) return;
    hi = 0; while (s && hi < 3000) begin hi++; half_s(s); end
    lo = 0; while (!s && lo < 3000) begin lo++; half_s(s); end
  endtask

  task automatic wait_rise();
    logic s;
    int g;
    g = 0; do begin half_s(s); g++; end while (s && g < 3000);
    g = 0; do begin half_s(s); g++; end while (!s && g < 3000);
  endtask

  task automatic rise_interval(output int c);
    logic s;
    c = 0;
    do begin half_s(s); c++; end while (s && c < 3000);
    do begin half_s(s); c++; end while (!s && c < 3000);
  endtask

  task automatic configure(input int n, input int ph, input bit dc, input int sel);
    logic s;
    en = 0;
    repeat (700) half_s(s);
    div = 8'(n); phase = 2'(ph); dc50 = dc; src_sel = 2'(sel);
    repeat (20) half_s(s);
  endtask

  task automatic start_lat(output int k);
    @(posedge bclk); #1;
    en = 1;
    k = 0;
    do begin @(posedge bclk); #1; k++; end while (!clk_out && k < 60);
  endtask

  initial begin
    #900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int k, hi, lo, ones, ehi, elo, c, sum, longs, rises;
    logic s, prev;
    rst_n = 0; en = 1; kill = 0; nudge = 0; dc50 = 0; div = 8'd4; phase = 0; src_sel = 0;

    // R1: quiet output while reset is held with enable high
    ones = 0;
    repeat (20) begin half_s(s); ones += int'(s); end
    check("R1 reset low", ones, 0);
    en = 0;
    @(posedge bclk); #1; rst_n = 1;

    configure(4, 0, 0, 0);
    ones = 0;
    repeat (40) begin half_s(s); ones += int'(s); end
    check("R1 idle low", ones, 0);

    // R2 R3 R4 R5: divisor sweep with both duty settings
    for (int n = 1; n <= 10; n++) begin
      for (int dc = 0; dc < 2; dc++) begin
        int nn;
        nn = (n == 10) ? 256 : n;
        configure(nn & 8'hff, n % 4, dc[0], 0);
        start_lat(k);
        check(nn == 1 ? "R3 R5 start latency" : "R5 start latency", k,
              (nn == 1) ? 4 + (n % 4) : 3 + (n % 4));
        measure(hi, lo);
        measure(hi, lo);
        if (nn == 1) begin ehi = 1; elo = 1; end
        else if (dc == 1 && (nn % 2) == 1) begin ehi = nn; elo = nn; end
        else begin ehi = 2 * (nn / 2); elo = 2 * nn - ehi; end
        if (nn == 1) begin
          check("R3 high halves", hi, ehi);
          check("R3 low halves", lo, elo);
        end else if (dc == 1 && (nn % 2) == 1) begin
          check("R4 high halves", hi, ehi);
          check("R4 low halves", lo, elo);
        end else begin
          check("R2 high halves", hi, ehi);
          check("R2 low halves", lo, elo);
        end
      end
    end

    // R9: other sources
    for (int sel = 1; sel < 4; sel++) begin
      configure(sel + 2, 0, 0, sel);
      start_lat(k);
      check("R9 start latency", k, 3);
      measure(hi, lo);
      measure(hi, lo);
      check("R9 high halves", hi, 2 * ((sel + 2) / 2));
      check("R9 low halves", lo, 2 * (sel + 2) - 2 * ((sel + 2) / 2));
    end

    // R10: divisor change while running
    configure(4, 0, 0, 0);
    start_lat(k);
    measure(hi, lo);
    div = 8'd7;
    repeat (40) half_s(s);
    measure(hi, lo);
    check("R10 high halves", hi, 6);
    check("R10 low halves", lo, 8);

    // R7: both nudge edges
    configure(5, 0, 0, 0);
    start_lat(k);
    measure(hi, lo);
    for (int e = 0; e < 2; e++) begin
      wait_rise();
      nudge = ~nudge;
      sum = 0; longs = 0;
      for (int i = 0; i < 6; i++) begin
        rise_interval(c);
        sum += c;
        if (c == 12) longs++;
      end
      check(e == 0 ? "R7 rising nudge sum" : "R7 falling nudge sum", sum, 62);
      check("R7 single long period", longs, 1);
    end

    // R6: clean stop
    configure(6, 0, 0, 0);
    start_lat(k);
    measure(hi, lo);
    wait_rise();
    en = 0;
    hi = 1;
    half_s(s);
    while (s && hi < 3000) begin hi++; half_s(s); end
    check("R6 last high full", hi, 6);
    rises = 0; prev = s;
    repeat (200) begin half_s(s); if (s && !prev) rises++; prev = s; end
    check("R6 no rise after stop", rises, 0);

    // R8: asynchronous kill and restart
    configure(4, 1, 0, 0);
    start_lat(k);
    measure(hi, lo);
    wait_rise();
    #0.5;
    kill = 1;
    #0.3;
    check("R8 immediate low", int'(clk_out), 0);
    ones = 0;
    repeat (10) begin half_s(s); ones += int'(s); end
    check("R8 low while killed", ones, 0);
    @(posedge bclk); #1;
    kill = 0;
    k = 0;
    do begin @(posedge bclk); #1; k++; end while (!clk_out && k < 60);
    check("R8 restart latency", k, 6);
    hi = 1;
    half_s(s);
    while (s && hi < 3000) begin hi++; half_s(s); end
    check("R8 first high full", hi, 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule